// File: doc/BRIEF.md
# PMBus Target Command Interface

This block is the byte-level command layer of a power-management bus target. An I2C bit engine in front of it handles the pins and hands over whole bytes, together with one-cycle pulses for start (including repeated start) and stop. The block decides whether each received byte is acknowledged. It decodes the device address and the command code, and it assembles write data into registers. When the engine asks for a byte during a read, the block supplies it.

Each output channel has an operating-mode byte and a multi-byte level word. Which channel is reached is chosen by a page register. Multi-byte values move least significant byte first in both directions. A sticky communication-fault flag records malformed or stalled transactions, and software clears it by writing a one. A bus timeout runs while a transaction is open and the bus sits idle, and it aborts that transaction.

Top module: `pmbus_target`

## Requirements
- R1: After a start, the first byte carries the device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). If the address differs from DEV_ADDR, that byte and every byte after it are not acknowledged until the next start, and no register or fault state changes.
- R2: Every received byte is answered one cycle later by a pulse on ack_valid, with ack = 1 meaning acknowledge and ack = 0 meaning no acknowledge.
- R3: The byte after a matching write address is always acknowledged and is captured as the command code.
- R4: Command 0x01 writes one byte to the operating mode of the selected channel. Command 0x21 writes the level of the selected channel as LVL_W/8 bytes, least significant byte first. The value is committed only when its final byte is received.
- R5: Command 0x00 is the page register. A written value below NCH is acknowledged and selects the channel for commands 0x01 and 0x21. A value of NCH or more is not acknowledged, sets the fault flag and leaves the page unchanged.
- R6: A read is address+write, command, repeated start, then address+read. After that, each tx_req is answered one cycle later by tx_valid with the next byte of the register, least significant byte first, and 0xFF once the register's bytes are used up. A read address that follows no command in the same frame is not acknowledged and sets the fault flag.
- R7: A stop or start that arrives after only part of a multi-byte write discards the partial value and sets the fault flag.
- R8: Each of the following sets the fault flag. A data byte sent to an unsupported command code, to the read-only version command 0x98, or beyond a command's length is not acknowledged. A read of an unsupported code returns 0xFF.
- R9: Command 0x7E reads back as a byte with the fault flag in bit 1. Writing it with bit 1 = 1 clears the flag, and bit 1 = 0 leaves it alone. Output comm_fault mirrors the flag.
- R10: Command 0x98 reads back the fixed revision VERSION (default 0x22).
- R11: When a transaction is open and bus_idle has been high for TIMEOUT_CYC consecutive cycles with no bus event, the transaction is aborted and the fault flag is set. Bytes are then not acknowledged until the next start.
- R12: After reset the fault flag, the page, every channel register, ack_valid and tx_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| bus_idle | input | 1 | Bus currently idle (no clocking activity) |
| rx_valid | input | 1 | Received byte available (one-cycle pulse) |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Engine requests the next read byte |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid | output | 1 | Read byte valid |
| tx_byte | output | 8 | Read byte |
| comm_fault | output | 1 | Sticky communication-fault flag |
| chan_oper | output | NCH*8 | Operating-mode byte of each channel |
| chan_level | output | NCH*LVL_W | Level word of each channel |

## Verification
A wrong frame state shows up on the very next byte. The ack bit for that byte flips, or a read returns 0xFF where register data was expected, one cycle after rx_valid or tx_req. A wrong byte counter shows up as a level word committed with its bytes swapped or too early, and this is visible on chan_level one cycle after the offending byte. A fault flag that is set or cleared wrongly appears on comm_fault one cycle after the triggering byte or bus event, and also in bit 1 of the next fault-register read. A timeout counter that is off by one shows as a fault either one idle cycle before the limit or missing at it.

// File: rtl/pmbus_tgt_pkg.sv
package pmbus_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } fr_state_e;

    localparam logic [7:0] CMD_PAGE  = 8'h00;
    localparam logic [7:0] CMD_OPER  = 8'h01;
    localparam logic [7:0] CMD_LEVEL = 8'h21;
    localparam logic [7:0] CMD_FAULT = 8'h7E;
    localparam logic [7:0] CMD_VER   = 8'h98;

    localparam int FAULT_BIT = 1;

endpackage

// File: rtl/pmbus_idle_timer.sv
module pmbus_idle_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == TW'(LIMIT - 1));
        if (!run || expire) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmbus_chan_bank.sv
module pmbus_chan_bank #(
    parameter int NCH   = 4,
    parameter int LVL_W = 16,
    parameter int PG_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PG_W-1:0]      sel,
    input  logic                 op_we,
    input  logic                 lvl_we,
    input  logic [LVL_W-1:0]     wdata,
    output logic [NCH*8-1:0]     op_flat,
    output logic [NCH*LVL_W-1:0] lvl_flat,
    output logic [7:0]           op_sel,
    output logic [LVL_W-1:0]     lvl_sel
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [7:0]       op_q;
        logic [LVL_W-1:0] lvl_q;
        logic             hit;

        assign hit = (sel == PG_W'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                op_q  <= '0;
                lvl_q <= '0;
            end else begin
                if (op_we && hit)  op_q  <= wdata[7:0];
                if (lvl_we && hit) lvl_q <= wdata;
            end
        end

        assign op_flat[ch*8 +: 8]          = op_q;
        assign lvl_flat[ch*LVL_W +: LVL_W] = lvl_q;
    end

    always_comb begin
        op_sel  = '0;
        lvl_sel = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (sel == PG_W'(ch)) begin
                op_sel  = op_flat[ch*8 +: 8];
                lvl_sel = lvl_flat[ch*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/pmbus_target.sv
module pmbus_target
    import pmbus_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int         NCH         = 4,
    parameter int         LVL_W       = 16,
    parameter int         TIMEOUT_CYC = 1000,
    parameter logic [7:0] VERSION     = 8'h22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_start,
    input  logic                 bus_stop,
    input  logic                 bus_idle,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 tx_req,
    output logic                 ack_valid,
    output logic                 ack,
    output logic                 tx_valid,
    output logic [7:0]           tx_byte,
    output logic                 comm_fault,
    output logic [NCH*8-1:0]     chan_oper,
    output logic [NCH*LVL_W-1:0] chan_level
);
    localparam int LVL_BYTES = LVL_W / 8;
    localparam int CW        = $clog2(LVL_BYTES + 2);
    localparam int PG_W      = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        fr_state_e        st;
        logic [7:0]       cmd;
        logic             have_cmd;
        logic [CW-1:0]    cnt;
        logic [LVL_W-1:0] lo;
        logic [PG_W-1:0]  page;
        logic             fault;
        logic             ack_v;
        logic             ack;
        logic             tx_v;
        logic [7:0]       tx;
    } fr_regs_t;

    fr_regs_t d, q;

    function automatic logic [CW-1:0] cmd_len(input logic [7:0] c);
        unique case (c)
            CMD_PAGE, CMD_OPER, CMD_FAULT, CMD_VER: cmd_len = CW'(1);
            CMD_LEVEL:                              cmd_len = CW'(LVL_BYTES);
            default:                                cmd_len = '0;
        endcase
    endfunction

    logic             open_tr, tmo_run, tmo_expire;
    logic             wr_op, wr_lvl, partial;
    logic [CW-1:0]    clen;
    logic [LVL_W-1:0] wval, rd_word, lvl_sel;
    logic [7:0]       op_sel;

    assign open_tr = (q.st == ST_ADDR) || (q.st == ST_CMD) ||
                     (q.st == ST_WDATA) || (q.st == ST_RDATA);
    assign tmo_run = open_tr && bus_idle && !rx_valid && !tx_req &&
                     !bus_start && !bus_stop;

    pmbus_idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmo_run),
        .expire (tmo_expire)
    );

    pmbus_chan_bank #(.NCH(NCH), .LVL_W(LVL_W), .PG_W(PG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (q.page),
        .op_we    (wr_op),
        .lvl_we   (wr_lvl),
        .wdata    (wval),
        .op_flat  (chan_oper),
        .lvl_flat (chan_level),
        .op_sel   (op_sel),
        .lvl_sel  (lvl_sel)
    );

    always_comb begin
        d       = q;
        d.ack_v = 1'b0;
        d.tx_v  = 1'b0;
        wr_op   = 1'b0;
        wr_lvl  = 1'b0;
        clen    = cmd_len(q.cmd);
        partial = (q.st == ST_WDATA) && (q.cnt != '0) && (q.cnt < clen);

        wval = q.lo;
        for (int b = 0; b < LVL_BYTES; b++)
            if (q.cnt == CW'(b)) wval[b*8 +: 8] = rx_byte;

        rd_word = '0;
        unique case (q.cmd)
            CMD_PAGE:  rd_word[PG_W-1:0]  = q.page;
            CMD_OPER:  rd_word[7:0]       = op_sel;
            CMD_LEVEL: rd_word            = lvl_sel;
            CMD_FAULT: rd_word[FAULT_BIT] = q.fault;
            CMD_VER:   rd_word[7:0]       = VERSION;
            default:   rd_word            = '0;
        endcase

        if (tmo_expire) begin
            d.st    = ST_IDLE;
            d.fault = 1'b1;
        end else if (bus_start) begin
            if (partial) d.fault = 1'b1;
            d.have_cmd = (q.st == ST_WDATA) && (q.cnt == '0);
            d.st       = ST_ADDR;
        end else if (bus_stop) begin
            if (partial) d.fault = 1'b1;
            d.have_cmd = 1'b0;
            d.st       = ST_IDLE;
        end else if (rx_valid) begin
            d.ack_v = 1'b1;
            d.ack   = 1'b0;
            unique case (q.st)
                ST_ADDR: begin
                    if (rx_byte[7:1] != DEV_ADDR) begin
                        d.st = ST_SKIP;
                    end else if (!rx_byte[0]) begin
                        d.st  = ST_CMD;
                        d.ack = 1'b1;
                    end else if (q.have_cmd) begin
                        d.st  = ST_RDATA;
                        d.cnt = '0;
                        d.ack = 1'b1;
                    end else begin
                        d.st    = ST_SKIP;
                        d.fault = 1'b1;
                    end
                end
                ST_CMD: begin
                    d.cmd = rx_byte;
                    d.cnt = '0;
                    d.st  = ST_WDATA;
                    d.ack = 1'b1;
                end
                ST_WDATA: begin
                    if (clen == '0 || q.cmd == CMD_VER || q.cnt >= clen ||
                        (q.cmd == CMD_PAGE && int'(rx_byte) >= NCH)) begin
                        d.st    = ST_SKIP;
                        d.fault = 1'b1;
                    end else begin
                        d.ack = 1'b1;
                        d.lo  = wval;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == clen - 1'b1) begin
                            unique case (q.cmd)
                                CMD_PAGE:  d.page = rx_byte[PG_W-1:0];
                                CMD_OPER:  wr_op  = 1'b1;
                                CMD_LEVEL: wr_lvl = 1'b1;
                                CMD_FAULT: if (rx_byte[FAULT_BIT]) d.fault = 1'b0;
                                default:   ;
                            endcase
                        end
                    end
                end
                default: ;
            endcase
        end else if (tx_req) begin
            d.tx_v = 1'b1;
            d.tx   = 8'hFF;
            if (q.st == ST_RDATA) begin
                if (clen == '0) begin
                    d.fault = 1'b1;
                end else if (q.cnt < clen) begin
                    for (int b = 0; b < LVL_BYTES; b++)
                        if (q.cnt == CW'(b)) d.tx = rd_word[b*8 +: 8];
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ack_valid  = q.ack_v;
    assign ack        = q.ack;
    assign tx_valid   = q.tx_v;
    assign tx_byte    = q.tx;
    assign comm_fault = q.fault;
endmodule

// File: rtl/pmbus_target_chk.sv
module pmbus_target_chk
    import pmbus_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int         NCH         = 4,
    parameter int         LVL_W       = 16,
    parameter int         TIMEOUT_CYC = 1000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_start,
    input logic                 bus_stop,
    input logic                 bus_idle,
    input logic                 rx_valid,
    input logic [7:0]           rx_byte,
    input logic                 tx_req,
    input logic                 ack_valid,
    input logic                 ack,
    input logic                 tx_valid,
    input logic                 comm_fault,
    input logic [NCH*LVL_W-1:0] chan_level,
    input fr_state_e            st_i,
    input logic [7:0]           page_i
);
    localparam int KW = $clog2(TIMEOUT_CYC + 1);

    logic          quiet;
    logic [KW-1:0] idle_cnt;

    assign quiet = bus_idle && !rx_valid && !tx_req && !bus_start && !bus_stop &&
                   (st_i == ST_ADDR || st_i == ST_CMD || st_i == ST_WDATA || st_i == ST_RDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          idle_cnt <= '0;
        else if (!quiet)                     idle_cnt <= '0;
        else if (idle_cnt != KW'(TIMEOUT_CYC)) idle_cnt <= idle_cnt + 1'b1;
    end

    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !bus_start && !bus_stop |=> ack_valid);

    assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !bus_start && !bus_stop && st_i == ST_ADDR &&
        rx_byte[7:1] != DEV_ADDR |=> ack_valid && !ack);

    assert_page_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(page_i) < NCH);

    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(chan_level));

    assert_read_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !rx_valid && !bus_start && !bus_stop |=> tx_valid);

    assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(comm_fault) |-> $past(rx_valid));

    assert_timeout_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt == KW'(TIMEOUT_CYC) |-> st_i == ST_IDLE);
endmodule

bind pmbus_target pmbus_target_chk #(
    .DEV_ADDR    (DEV_ADDR),
    .NCH         (NCH),
    .LVL_W       (LVL_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .bus_idle   (bus_idle),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .tx_req     (tx_req),
    .ack_valid  (ack_valid),
    .ack        (ack),
    .tx_valid   (tx_valid),
    .comm_fault (comm_fault),
    .chan_level (chan_level),
    .st_i       (q.st),
    .page_i     (8'(q.page))
);

// File: tb/test_pmbus_target.sv
module test_pmbus_target;
    localparam int NCH   = 4;
    localparam int LVL_W = 16;
    localparam int TMO   = 64;
    localparam int NV    = 66;

    localparam logic [1:0] OS = 2'd0, OP = 2'd1, OW = 2'd2, OR = 2'd3;

    // {op, req, data, expected}
    localparam logic [21:0] VEC [0:NV-1] = '{
        // R4: level of channel 0 = 0x1234, LSB first
        {OS,4'd0,8'h00,8'h00}, {OW,4'd1,8'h94,8'h01}, {OW,4'd3,8'h21,8'h01},
        {OW,4'd4,8'h34,8'h01}, {OW,4'd4,8'h12,8'h01}, {OP,4'd0,8'h00,8'h00},
        // R6: read back, then 0xFF past the end
        {OS,4'd0,8'h00,8'h00}, {OW,4'd6,8'h94,8'h01}, {OW,4'd6,8'h21,8'h01},
        {OS,4'd0,8'h00,8'h00}, {OW,4'd6,8'h95,8'h01}, {OR,4'd6,8'h00,8'h34},
        {OR,4'd6,8'h00,8'h12}, {OR,4'd6,8'h00,8'hFF}, {OP,4'd0,8'h00,8'h00},
        // R5: select page 2
        {OS,4'd0,8'h00,8'h00}, {OW,4'd5,8'h94,8'h01}, {OW,4'd5,8'h00,8'h01},
        {OW,4'd5,8'h02,8'h01}, {OP,4'd0,8'h00,8'h00},
        // R4: operating mode of channel 2 = 0x80
        {OS,4'd0,8'h00,8'h00}, {OW,4'd4,8'h94,8'h01}, {OW,4'd4,8'h01,8'h01},
        {OW,4'd4,8'h80,8'h01}, {OP,4'd0,8'h00,8'h00},
        // R5: page reads back
        {OS,4'd0,8'h00,8'h00}, {OW,4'd5,8'h94,8'h01}, {OW,4'd5,8'h00,8'h01},
        {OS,4'd0,8'h00,8'h00}, {OW,4'd5,8'h95,8'h01}, {OR,4'd5,8'h00,8'h02},
        {OP,4'd0,8'h00,8'h00},
        // R4: level of channel 2 = 0xABCD
        {OS,4'd0,8'h00,8'h00}, {OW,4'd4,8'h94,8'h01}, {OW,4'd4,8'h21,8'h01},
        {OW,4'd4,8'hCD,8'h01}, {OW,4'd4,8'hAB,8'h01}, {OP,4'd0,8'h00,8'h00},
        // R6: read channel 2 level
        {OS,4'd0,8'h00,8'h00}, {OW,4'd6,8'h94,8'h01}, {OW,4'd6,8'h21,8'h01},
        {OS,4'd0,8'h00,8'h00}, {OW,4'd6,8'h95,8'h01}, {OR,4'd6,8'h00,8'hCD},
        {OR,4'd6,8'h00,8'hAB}, {OP,4'd0,8'h00,8'h00},
        // R1: foreign address, whole frame NACKed
        {OS,4'd0,8'h00,8'h00}, {OW,4'd1,8'h90,8'h00}, {OW,4'd1,8'h21,8'h00},
        {OW,4'd1,8'h34,8'h00}, {OP,4'd0,8'h00,8'h00},
        // R10: revision register
        {OS,4'd0,8'h00,8'h00}, {OW,4'd10,8'h94,8'h01}, {OW,4'd10,8'h98,8'h01},
        {OS,4'd0,8'h00,8'h00}, {OW,4'd10,8'h95,8'h01}, {OR,4'd10,8'h00,8'h22},
        {OR,4'd10,8'h00,8'hFF}, {OP,4'd0,8'h00,8'h00},
        // R4: operating mode of channel 2 reads back
        {OS,4'd0,8'h00,8'h00}, {OW,4'd4,8'h94,8'h01}, {OW,4'd4,8'h01,8'h01},
        {OS,4'd0,8'h00,8'h00}, {OW,4'd4,8'h95,8'h01}, {OR,4'd4,8'h00,8'h80},
        {OP,4'd0,8'h00,8'h00}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_start = 1'b0, bus_stop = 1'b0, bus_idle = 1'b0;
    logic                 rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]           rx_byte = '0;
    logic                 ack_valid, ack, tx_valid, comm_fault;
    logic [7:0]           tx_byte;
    logic [NCH*8-1:0]     chan_oper;
    logic [NCH*LVL_W-1:0] chan_level;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pmbus_target #(
        .DEV_ADDR(7'h4A), .NCH(NCH), .LVL_W(LVL_W), .TIMEOUT_CYC(TMO), .VERSION(8'h22)
    ) i_pmbus_target (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_idle(bus_idle), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .comm_fault(comm_fault), .chan_oper(chan_oper), .chan_level(chan_level)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, input logic exp_ack, input string req);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        check(ack_valid && ack == exp_ack, req, {ack_valid, ack}, {1'b1, exp_ack});
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        check(tx_valid && tx_byte == exp, req, {tx_valid, tx_byte}, {1'b1, exp});
    endtask

    task automatic read_fault(input logic [7:0] exp, input string req);
        do_start(); wr(8'h94, 1'b1, req); wr(8'h7E, 1'b1, req);
        do_start(); wr(8'h95, 1'b1, req); rd(exp, req); do_stop();
    endtask

    task automatic clear_fault();
        do_start(); wr(8'h94, 1'b1, "R9"); wr(8'h7E, 1'b1, "R9"); wr(8'h02, 1'b1, "R9"); do_stop();
        check(comm_fault == 1'b0, "R9", comm_fault, 0);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(comm_fault == 0 && ack_valid == 0 && tx_valid == 0, "R12",
              {comm_fault, ack_valid, tx_valid}, 0);
        check(chan_oper == '0 && chan_level == '0, "R12", chan_level[15:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [3:0] rq;
            logic [7:0] dat, ex;
            string      tag;
            {op, rq, dat, ex} = VEC[i];
            tag = $sformatf("R%0d", rq);
            case (op)
                OS: do_start();
                OP: do_stop();
                OW: wr(dat, ex[0], tag);
                default: rd(ex, tag);
            endcase
        end

        // R4: channel outputs are page-isolated
        check(chan_level[15:0] == 16'h1234, "R4", chan_level[15:0], 16'h1234);
        check(chan_level[47:32] == 16'hABCD, "R4", chan_level[47:32], 16'hABCD);
        check(chan_oper[23:16] == 8'h80 && chan_oper[7:0] == 8'h00, "R4", chan_oper, 32'h0080_0000);
        // R1: foreign frame left the fault flag alone
        check(comm_fault == 1'b0, "R1", comm_fault, 0);

        // R5: out-of-range page
        do_start(); wr(8'h94, 1'b1, "R5"); wr(8'h00, 1'b1, "R5"); wr(8'h07, 1'b0, "R5"); do_stop();
        check(comm_fault == 1'b1, "R5", comm_fault, 1);
        do_start(); wr(8'h94, 1'b1, "R5"); wr(8'h00, 1'b1, "R5");
        do_start(); wr(8'h95, 1'b1, "R5"); rd(8'h02, "R5"); do_stop();

        // R9: fault reads in bit 1; writing bit 1 = 0 keeps it
        read_fault(8'h02, "R9");
        do_start(); wr(8'h94, 1'b1, "R9"); wr(8'h7E, 1'b1, "R9"); wr(8'h01, 1'b1, "R9"); do_stop();
        check(comm_fault == 1'b1, "R9", comm_fault, 1);
        clear_fault();
        read_fault(8'h00, "R9");

        // R8: unsupported code, data NACKed
        do_start(); wr(8'h94, 1'b1, "R8"); wr(8'h55, 1'b1, "R3"); wr(8'h01, 1'b0, "R8"); do_stop();
        check(comm_fault == 1'b1, "R8", comm_fault, 1);
        clear_fault();
        // R8: unsupported read returns 0xFF
        do_start(); wr(8'h94, 1'b1, "R8"); wr(8'h55, 1'b1, "R8");
        do_start(); wr(8'h95, 1'b1, "R8"); rd(8'hFF, "R8"); do_stop();
        check(comm_fault == 1'b1, "R8", comm_fault, 1);
        clear_fault();
        // R8: revision is read-only
        do_start(); wr(8'h94, 1'b1, "R8"); wr(8'h98, 1'b1, "R8"); wr(8'h33, 1'b0, "R8"); do_stop();
        check(comm_fault == 1'b1, "R8", comm_fault, 1);
        clear_fault();
        // R8: byte beyond command length
        do_start(); wr(8'h94, 1'b1, "R8"); wr(8'h01, 1'b1, "R8");
        wr(8'h05, 1'b1, "R8"); wr(8'h06, 1'b0, "R8"); do_stop();
        check(comm_fault == 1'b1 && chan_oper[23:16] == 8'h05, "R8", chan_oper[23:16], 8'h05);
        clear_fault();

        // R7: partial level write discarded
        do_start(); wr(8'h94, 1'b1, "R7"); wr(8'h21, 1'b1, "R7"); wr(8'h77, 1'b1, "R7"); do_stop();
        check(comm_fault == 1'b1, "R7", comm_fault, 1);
        check(chan_level[47:32] == 16'hABCD, "R7", chan_level[47:32], 16'hABCD);
        clear_fault();
        // R7: partial write cut by repeated start
        do_start(); wr(8'h94, 1'b1, "R7"); wr(8'h21, 1'b1, "R7"); wr(8'h66, 1'b1, "R7");
        do_start();
        check(comm_fault == 1'b1, "R7", comm_fault, 1);
        do_stop();
        check(chan_level[47:32] == 16'hABCD, "R7", chan_level[47:32], 16'hABCD);
        clear_fault();

        // R6: read address with no command in frame
        do_start(); wr(8'h95, 1'b0, "R6"); do_stop();
        check(comm_fault == 1'b1, "R6", comm_fault, 1);
        clear_fault();

        // R11: one cycle short of the limit, then exactly the limit
        do_start(); wr(8'h94, 1'b1, "R11");
        bus_idle = 1'b1;
        repeat (TMO - 1) @(negedge clk);
        bus_idle = 1'b0;
        check(comm_fault == 1'b0, "R11", comm_fault, 0);
        @(negedge clk);
        bus_idle = 1'b1;
        repeat (TMO) @(negedge clk);
        bus_idle = 1'b0;
        check(comm_fault == 1'b1, "R11", comm_fault, 1);
        wr(8'h21, 1'b0, "R11");
        do_stop();
        clear_fault();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule